// File: doc/BRIEF.md
# Prioritized Serial-Port Interrupt Identifier

This block folds the four interrupt conditions of a serial port into one interrupt line and a 3-bit identification value that software reads. The four conditions are a receiver fault or line break, a received character waiting, an empty transmit holding register, and a change on the modem status inputs. Each condition has its own enable bit. The identification value has two parts: a pending-not flag, and a 2-bit class code for the most urgent class that is both enabled and active.

A master gate bit controls only the external interrupt line. While the gate is low, the pending state and the identification value are still computed as usual. The identification value is purely combinational, so it follows the inputs within the same cycle. Software reads it over and over, servicing one class per read, until the pending-not flag reads 1.

The condition sources keep their own state and clear it themselves. The transmit-empty class is the one exception. It has no status register to be cleared through, so reading the identification while that class is reported acknowledges it. The acknowledgement lasts until the holding register is written again.

Top module: `sio_irq_ident`

## Requirements
- R1: A class can be pending only while its enable bit is 1. The enable bits are: bit 3 receiver fault/break, bit 2 received data, bit 1 transmit empty, bit 0 modem change.
- R2: Bit 0 of `id_val` is the pending-not flag. It is 0 when at least one enabled class is active and 1 when none is.
- R3: Bits [2:1] of `id_val` hold the class code: 3 for receiver fault/break, 2 for received data, 1 for transmit empty, 0 for modem change.
- R4: When several classes are pending, only the one with the highest code is reported.
- R5: When nothing is pending, `id_val` equals 3'b001, which means class code 0.
- R6: `irq` is 1 exactly when `gate_en` is 1 and some class is pending. With `gate_en` at 0, `irq` stays 0 while `id_val` still reports the pending class.
- R7: If `id_rd` is sampled high on a clock edge while `id_val` reports class 1, the transmit-empty class is suppressed from the next cycle on.
- R8: If `thr_write` is sampled high on a clock edge, the suppression is removed from the next cycle on. The transmit-empty class then returns whenever `thr_empty` is 1. A write in the same cycle as an acknowledging read takes precedence.
- R9: `id_val` and `irq` respond to a change of any condition, enable or gate input in the same cycle, with no register in between.
- R10: An identification read while a class other than 1 is reported does not suppress the transmit-empty class.
- R11: Reset removes any transmit-empty suppression.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_mask | input | 4 | Per-class enable bits (bit 3 fault, 2 data, 1 tx empty, 0 modem) |
| gate_en | input | 1 | Master gate for the external interrupt line |
| cond_rxerr | input | 1 | Receiver fault or break condition active |
| cond_rxdata | input | 1 | Received character available |
| thr_empty | input | 1 | Transmit holding register is empty |
| cond_modem | input | 1 | Modem status change seen |
| thr_write | input | 1 | Strobe: the transmit holding register is being written |
| id_rd | input | 1 | Strobe: software is reading the identification value |
| irq | output | 1 | Gated interrupt request, active high |
| id_val | output | 3 | {class code[1:0], pending-not flag} |

## Verification
On every cycle, the assertions check four things: the external line matches the inverted pending-not flag whenever the gate is open, the line stays low whenever the gate is closed, an enabled receiver fault always shows code 3, and an idle value carries code 0. They also check the acknowledge and re-arm timing of the transmit-empty suppression one cycle after a read or a write. Only the bench scenarios can show the rest: the full priority ordering across mixed enable and condition patterns, that a read of a different class leaves the transmit-empty class alone, that a write takes precedence over a simultaneous acknowledging read, and that reset clears a suppression.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
    localparam int NUM_SRC = 4;
    localparam int CODE_W  = $clog2(NUM_SRC);

    typedef enum logic [CODE_W-1:0] {
        CLS_MODEM = 2'd0,
        CLS_TXE   = 2'd1,
        CLS_RXD   = 2'd2,
        CLS_RXERR = 2'd3
    } irq_cls_e;

    typedef struct packed {
        logic ack;
    } txack_state_t;
endpackage

// File: rtl/sio_irq_prio.sv
module sio_irq_prio #(
    parameter int NUM_SRC = 4,
    localparam int CODE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [CODE_W-1:0]  code
);
    // Highest set index wins; the code stays 0 when no request is set.
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                code = CODE_W'(i);
            end
        end
    end

    assign any = |req;

    // An idle encoder must report code 0 (R5)
    always_comb begin
        if (!any) begin
            AST_IDLE_CODE_ZERO: assert (code == '0); // R5
        end
    end
endmodule

// File: rtl/sio_irq_txack.sv
module sio_irq_txack
    import sio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic id_rd,
    input  logic tx_reported,
    input  logic thr_write,
    output logic ack_q
);
    txack_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (id_rd && tx_reported) begin
            state_d.ack = 1'b1;
        end
        if (thr_write) begin
            state_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ack_q = state_q.ack;

    AST_WRITE_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        thr_write |=> !ack_q); // R8
    AST_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && tx_reported && !thr_write) |=> ack_q); // R7
endmodule

// File: rtl/sio_irq_ident.sv
module sio_irq_ident
    import sio_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  en_mask,
    input  logic                gate_en,
    input  logic                cond_rxerr,
    input  logic                cond_rxdata,
    input  logic                thr_empty,
    input  logic                cond_modem,
    input  logic                thr_write,
    input  logic                id_rd,
    output logic                irq,
    output logic [CODE_W:0]     id_val
);
    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] req;
    logic               any_pend;
    logic [CODE_W-1:0]  cls_code;
    logic               tx_ack_q;
    logic               tx_reported;

    // Raw condition vector; the index is the class code.
    always_comb begin
        raw            = '0;
        raw[CLS_MODEM] = cond_modem;
        raw[CLS_TXE]   = thr_empty & ~tx_ack_q;
        raw[CLS_RXD]   = cond_rxdata;
        raw[CLS_RXERR] = cond_rxerr;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        assign req[g] = raw[g] & en_mask[g];
    end

    sio_irq_prio #(
        .NUM_SRC (NUM_SRC)
    ) u_prio (
        .req  (req),
        .any  (any_pend),
        .code (cls_code)
    );

    assign tx_reported = any_pend && (cls_code == CLS_TXE);

    sio_irq_txack u_txack (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_rd       (id_rd),
        .tx_reported (tx_reported),
        .thr_write   (thr_write),
        .ack_q       (tx_ack_q)
    );

    assign id_val = {cls_code, ~any_pend};
    assign irq    = gate_en & any_pend;

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> !irq); // R6
    AST_LINE_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> (irq == !id_val[0])); // R2
    AST_FAULT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_rxerr && en_mask[CLS_RXERR]) |-> (id_val == {CLS_RXERR, 1'b0})); // R4
    AST_IDLE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        id_val[0] |-> (id_val[CODE_W:1] == '0)); // R5
    AST_TX_ACK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && id_val == {CLS_TXE, 1'b0} && !thr_write) |=> (id_val != {CLS_TXE, 1'b0})); // R7
endmodule

// File: tb/sio_irq_ident_tb.sv
module sio_irq_ident_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    // stim = {en_mask[3:0], gate_en, rxerr, rxdata, thr_empty, modem}
    // exp  = {irq, id_val[2:0]}
    localparam logic [8:0] STIM [NVEC] = '{
        9'b1111_1_0000, 9'b1111_1_0001, 9'b1111_1_0010, 9'b1111_1_0100,
        9'b1111_1_1000, 9'b1111_1_1111, 9'b1111_1_0111, 9'b1111_1_0011,
        9'b0111_1_1111, 9'b0001_1_1110, 9'b1000_1_0111, 9'b1111_0_0100,
        9'b0000_0_1111, 9'b0101_1_1011
    };
    localparam logic [3:0] EXPV [NVEC] = '{
        4'b0_001, 4'b1_000, 4'b1_010, 4'b1_100,
        4'b1_110, 4'b1_110, 4'b1_100, 4'b1_010,
        4'b1_100, 4'b0_001, 4'b0_001, 4'b0_100,
        4'b0_001, 4'b1_000
    };
    localparam string VREQ [NVEC] = '{
        "R5", "R3", "R3", "R3", "R3", "R4", "R4", "R4",
        "R1", "R1", "R1", "R6", "R2", "R1"
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] en_mask = '0;
    logic       gate_en = 1'b0;
    logic       cond_rxerr = 1'b0;
    logic       cond_rxdata = 1'b0;
    logic       thr_empty = 1'b0;
    logic       cond_modem = 1'b0;
    logic       thr_write = 1'b0;
    logic       id_rd = 1'b0;
    logic       irq;
    logic [2:0] id_val;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_irq_ident u_dut (
        .clk, .rst_n, .en_mask, .gate_en, .cond_rxerr, .cond_rxdata,
        .thr_empty, .cond_modem, .thr_write, .id_rd, .irq, .id_val
    );

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if ({irq, id_val} !== exp) begin
            errors++;
            $display("FAIL %s: actual irq/id=%b expected %b", req, {irq, id_val}, exp);
        end
    endtask

    task automatic apply(input logic [8:0] s);
        {en_mask, gate_en, cond_rxerr, cond_rxdata, thr_empty, cond_modem} = s;
    endtask

    task automatic pulse_read();
        @(negedge clk) id_rd = 1'b1;
        @(negedge clk) id_rd = 1'b0;
        #1;
    endtask

    task automatic pulse_write();
        @(negedge clk) thr_write = 1'b1;
        @(negedge clk) thr_write = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog (all R): actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 / R2: reset state with only tx empty enabled
        apply(9'b0010_1_0010);
        #1 check("R11 reset", 4'b1_010);
        rst_n = 1'b1;

        // Table walk: combinational response within the same cycle (R9)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            apply(STIM[i]);
            #1 check(VREQ[i], EXPV[i]);
        end

        // R7: read while class 1 reported suppresses it
        @(negedge clk) apply(9'b0010_1_0010);
        #1 check("R7 before read", 4'b1_010);
        pulse_read();
        check("R7 after read", 4'b0_001);

        // R8: write rearms; class returns once empty again
        @(negedge clk) thr_empty = 1'b0;
        pulse_write();
        check("R8 busy after write", 4'b0_001);
        @(negedge clk) thr_empty = 1'b1;
        #1 check("R8 empty again", 4'b1_010);

        // R8: write beats a simultaneous acknowledging read
        @(negedge clk) begin id_rd = 1'b1; thr_write = 1'b1; end
        @(negedge clk) begin id_rd = 1'b0; thr_write = 1'b0; end
        #1 check("R8 write wins", 4'b1_010);

        // R10: read while class 2 reported keeps tx pending
        @(negedge clk) apply(9'b1111_1_0110);
        #1 check("R10 data shown", 4'b1_100);
        pulse_read();
        @(negedge clk) cond_rxdata = 1'b0;
        #1 check("R10 tx still pending", 4'b1_010);

        // R6: gate closed while tx pending
        @(negedge clk) gate_en = 1'b0;
        #1 check("R6 gated", 4'b0_010);
        @(negedge clk) gate_en = 1'b1;

        // R11: suppress, then reset clears it
        pulse_read();
        check("R7 suppressed again", 4'b0_001);
        @(negedge clk) rst_n = 1'b0;
        #1 check("R11 reset clears ack", 4'b1_010);
        @(negedge clk) rst_n = 1'b1;

        // R9: modem change seen in the same cycle
        @(negedge clk) apply(9'b0001_1_0000);
        #1 check("R9 idle", 4'b0_001);
        cond_modem = 1'b1;
        #1 check("R9 same-cycle", 4'b1_000);

        finish_run();
    end
endmodule